// File: doc/BRIEF.md
# Phase-Shifted Multichannel PWM Generator

This block produces four raw pulse-width-modulated bits from one shared time base. A prescaler splits the system clock into ticks, and an 8-bit period counter advances once per tick. Every channel adds its own phase value to that counter, modulo 256, and compares the sum with its own duty value. Moving the phase therefore slides the pulse inside the period while the pulse width stays the same. This is how interleaved multi-phase drive is built. With a 10 MHz clock, a prescale of 1 gives about 19.5 kHz, 7 gives about 4.9 kHz and 781 gives 50 Hz: the frequency is f_clk / ((prescale + 1) * 256).

Duty and phase values are copied into per-channel shadow registers only at the wrap from count 255 to count 0, so a value written in the middle of a period cannot cut a pulse short. A one-cycle period-start pulse marks the first clock of every period. Dead-time shaping, fault shutdown and output enables belong to the stages that follow this block.

Top module: `pwm_phase_gen`

## Requirements
- R1: While reset is held and afterwards, pwm_out and period_start are 0. The shadow duty values reset to 0, so every output stays low until the first period start, whatever duty_in holds.
- R2: Each count value lasts prescale+1 clock cycles, so a full period lasts 256*(prescale+1) cycles. prescale is an unsigned 10-bit value.
- R3: period_start is high for exactly one cycle per period. That cycle is the first cycle of count 0, and period_start is low on every other cycle.
- R4: For every count k of a period, pwm_out[i] is 1 exactly when ((k + phase_i) mod 256) < duty_i. Here duty_i is duty_in[8i+7:8i] and phase_i is phase_in[8i+7:8i]. Each channel uses only its own fields.
- R5: A duty of 0 keeps the channel low for the whole period. A duty of 255 keeps it high for all counts but one in every 256.
- R6: Per period, a channel is high for exactly duty_i*(prescale+1) cycles, whatever its phase.
- R7: duty_in and phase_in are sampled only at the clock edge where period_start rises. A change made during a period has no effect on pwm_out until the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale | input | 10 | Clock cycles per count, minus one |
| duty_in | input | 32 | Four 8-bit duty values, channel i at bits 8i+7:8i |
| phase_in | input | 32 | Four 8-bit phase offsets, channel i at bits 8i+7:8i |
| pwm_out | output | 4 | Registered raw PWM bit per channel |
| period_start | output | 1 | One-cycle pulse on the first cycle of each period |

## Verification
The bench builds the block with its default parameters: four channels, an 8-bit count and a 10-bit prescaler. Because the count is 8 bits wide, each full period can be compared cycle by cycle against a model written from the requirements. Prescale values from 0 to 9 keep a period at or below 2560 cycles, so the duty extremes, wrapping phases, a mid-period change of the inputs and the spacing of period pulses all fit in one short run. The longest settings, such as the 50 Hz case, follow the same counting rule and would only lengthen the run.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  localparam int unsigned DEF_CHANNELS   = 4;
  localparam int unsigned DEF_COUNT_W    = 8;
  localparam int unsigned DEF_PRESCALE_W = 10;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned PRE_W = pwm_phase_pkg::DEF_PRESCALE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  logic [PRE_W-1:0] div_cnt;
  logic             tick_q;

  // The >= compare restarts cleanly if prescale shrinks mid-count.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else if (div_cnt >= prescale) begin
      div_cnt <= '0;
      tick_q  <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      tick_q  <= 1'b0;
    end
  end

  assign tick = tick_q;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick_q && prescale != '0) |=> !tick_q); // R2
endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
  parameter int unsigned CNT_W = pwm_phase_pkg::DEF_COUNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count_nxt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;

  assign wrap      = tick && (count_q == CNT_MAX);
  assign count_nxt = tick ? count_q + 1'b1 : count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_nxt;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (count_q == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count_q)); // R2
endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
  parameter int unsigned CNT_W = pwm_phase_pkg::DEF_COUNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [CNT_W-1:0] phase_in,
  output logic             pwm
);
  logic [CNT_W-1:0] duty_sh, phase_sh;
  logic [CNT_W-1:0] duty_eff, phase_eff, shifted;
  logic             pwm_q;

  // Values being loaded at a wrap apply already to count 0.
  assign duty_eff  = load ? duty_in  : duty_sh;
  assign phase_eff = load ? phase_in : phase_sh;
  assign shifted   = count_nxt + phase_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_sh  <= '0;
      phase_sh <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (load) begin
        duty_sh  <= duty_in;
        phase_sh <= phase_in;
      end
      pwm_q <= (shifted < duty_eff);
    end
  end

  assign pwm = pwm_q;

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
    (duty_sh == '0 && !load) |=> !pwm_q); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(duty_sh) && $stable(phase_sh))); // R7
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
  parameter int unsigned CHANNELS = pwm_phase_pkg::DEF_CHANNELS,
  parameter int unsigned CNT_W    = pwm_phase_pkg::DEF_COUNT_W,
  parameter int unsigned PRE_W    = pwm_phase_pkg::DEF_PRESCALE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PRE_W-1:0]          prescale,
  input  logic [CHANNELS*CNT_W-1:0] duty_in,
  input  logic [CHANNELS*CNT_W-1:0] phase_in,
  output logic [CHANNELS-1:0]       pwm_out,
  output logic                      period_start
);
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] count_nxt;
  logic             start_q;

  pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .prescale (prescale),
    .tick     (tick)
  );

  pwm_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .count_nxt (count_nxt),
    .wrap      (wrap)
  );

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
    pwm_lane #(.CNT_W(CNT_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .load      (wrap),
      .count_nxt (count_nxt),
      .duty_in   (duty_in[ch*CNT_W +: CNT_W]),
      .phase_in  (phase_in[ch*CNT_W +: CNT_W]),
      .pwm       (pwm_out[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= wrap;
  end

  assign period_start = start_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q); // R3
endmodule

// File: tb/tb_pwm_phase_gen.sv
module tb_pwm_phase_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam logic [9:0]  V_PRE   [NV] = '{10'd0, 10'd1, 10'd0, 10'd2, 10'd9};
  localparam logic [31:0] V_DUTY  [NV] = '{32'h20FF4080, 32'hFF00C0C0, 32'h0080FE01,
                                           32'hF010AA55, 32'h80808080};
  localparam logic [31:0] V_PHASE [NV] = '{32'h00000000, 32'hC0804000, 32'h10F001FF,
                                           32'h80604020, 32'hC0804000};

  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  prescale;
  logic [31:0] duty_in, phase_in;
  logic [3:0]  pwm_out;
  logic        period_start;
  int          checks = 0;
  int          fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_phase_gen dut (
    .clk          (clk),
    .rst          (rst),
    .prescale     (prescale),
    .duty_in      (duty_in),
    .phase_in     (phase_in),
    .pwm_out      (pwm_out),
    .period_start (period_start)
  );

  task automatic report(input bit ok, input string req, input string what,
                        input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Waits for the next period start (skipping one in progress) and checks
  // the whole period; optionally changes the inputs at cycle swap_at.
  task automatic check_period(input int p, input logic [31:0] d, input logic [31:0] ph,
                              input int swap_at, input logic [31:0] nd,
                              input logic [31:0] nph, input string tag);
    int len;
    int k;
    int mism  [4];
    int highs [4];
    int ps_bad;
    len = 256 * (p + 1);
    ps_bad = 0;
    for (int c = 0; c < 4; c++) begin
      mism[c] = 0;
      highs[c] = 0;
    end
    @(negedge clk);
    while (period_start !== 1'b1) @(negedge clk);
    for (int n = 0; n < len; n++) begin
      k = n / (p + 1);
      for (int c = 0; c < 4; c++) begin
        bit expv;
        expv = ((k + int'(ph[8*c +: 8])) % 256) < int'(d[8*c +: 8]);
        if (pwm_out[c] !== expv) mism[c]++;
        if (pwm_out[c] === 1'b1) highs[c]++;
      end
      if ((n == 0) != (period_start === 1'b1)) ps_bad++;
      if (n == swap_at) begin
        duty_in  = nd;
        phase_in = nph;
      end
      @(negedge clk);
    end
    report(period_start === 1'b1, "R2", {tag, " next period start after 256*(prescale+1)"},
           int'(period_start), 1);
    report(ps_bad == 0, "R3", {tag, " period_start cycles off the first count-0 cycle"},
           ps_bad, 0);
    for (int c = 0; c < 4; c++) begin
      int dv;
      dv = int'(d[8*c +: 8]);
      report(mism[c] == 0, "R4", $sformatf("%s ch%0d pattern mismatching cycles", tag, c),
             mism[c], 0);
      if (dv == 0 || dv == 255)
        report(highs[c] == dv * (p + 1), "R5",
               $sformatf("%s ch%0d high cycles at extreme duty", tag, c), highs[c], dv * (p + 1));
      else
        report(highs[c] == dv * (p + 1), "R6",
               $sformatf("%s ch%0d high cycles per period", tag, c), highs[c], dv * (p + 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R2 watchdog: cycles %0d expected fewer than %0d", 150000, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    rst      = 1'b1;
    prescale = 10'd0;
    duty_in  = 32'hFFFFFFFF;
    phase_in = 32'h0;
    repeat (5) @(negedge clk);
    // R1: outputs low in reset
    report(pwm_out == 4'b0 && period_start == 1'b0, "R1", "outputs during reset",
           int'({period_start, pwm_out}), 0);
    rst = 1'b0;
    // R1: shadow duties are 0 until the first period start
    bad = 0;
    for (int n = 0; n < 200; n++) begin
      if (pwm_out !== 4'b0 || period_start !== 1'b0) bad++;
      @(negedge clk);
    end
    report(bad == 0, "R1", "non-zero output cycles before first period start", bad, 0);

    // Table of vectors: R2 R3 R4 R5 R6 across prescales and phases
    for (int v = 0; v < NV; v++) begin
      prescale = V_PRE[v];
      duty_in  = V_DUTY[v];
      phase_in = V_PHASE[v];
      check_period(int'(V_PRE[v]), V_DUTY[v], V_PHASE[v], -1, 32'h0, 32'h0,
                   $sformatf("vec%0d", v));
    end

    // R7: mid-period change stays invisible until the next period
    prescale = 10'd0;
    duty_in  = 32'h64646464;
    phase_in = 32'h00000000;
    check_period(0, 32'h64646464, 32'h00000000, 50, 32'hC8C8C8C8, 32'h80808080, "R7 old");
    check_period(0, 32'hC8C8C8C8, 32'h80808080, -1, 32'h0, 32'h0, "R7 new");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule